// File: doc/BRIEF.md
# Up/Down Timer with Capture and Reload

This block is a 16-bit counter that advances once per clock while running, paired with a 16-bit hold register. The hold register acts as the reload value or as the capture target, depending on the mode. An external trigger pin passes through a synchronizer and a two-state edge detector. A falling edge on it can capture the running count, force a reload, or only raise an event flag. In the up/down variant of reload mode, the same pin sets the count direction instead.

A clock-generation mode toggles an output pin on every reload, which produces a 50% duty square wave at half the wrap rate. Two sticky flags record wraps and external events. Their OR forms the single interrupt request.

Software reaches the block through a flat register port: a one-cycle write strobe with address and data, and a combinational read port with its own address. There are four registers:

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Count |
| 2 | Hold (reload/capture) |
| 3 | Flags |

The edge detector is a state machine with two states:
- `TRG_HIGH` (the armed state, reset state) moves to `TRG_LOW` when the synchronized pin reads 0. A falling-edge event is raised in that same cycle.
- `TRG_LOW` returns to `TRG_HIGH` when the synchronized pin reads 1.

The counting behaviour is selected by the mode field. `MODE_CAPT` and the reserved code behave alike; the other two are `MODE_RELOAD` and `MODE_CLKGEN`.

Top module: `updown_capture_timer`

## Requirements
- R1: In capture mode (control bits [2:1] = 00) with run (control bit 0) set, the count steps by +1 per clock. From all ones it wraps to zero and sets the overflow flag (flags bit 0).
- R2: After reset, control, count, hold and flags read zero, and clk_out and irq are low. The register addresses are 0 control, 1 count, 2 hold and 3 flags. A write to control stores run in bit 0, mode in bits [2:1], external enable in bit 3 and direction enable in bit 4, and reads back the same.
- R3: With external enable (control bit 3) set in capture mode, a falling edge on trig_in copies the count into hold and sets the event flag (flags bit 1). The action lands three clocks after the pin falls. If a software count write lands in the same cycle, hold receives the count from before the write.
- R4: With external enable clear, a falling edge on trig_in changes neither hold, count nor flags.
- R5: In reload mode (control bits [2:1] = 01) with direction enable clear, the count counts up. From all ones it loads the hold value and sets the overflow flag.
- R6: In reload mode with external enable set and direction enable clear, a falling edge on trig_in loads the count from hold and sets the event flag, even while stopped.
- R7: In reload mode with direction enable (control bit 4) set, a synchronized trig_in high counts up and low counts down. Counting down from the hold value goes to all ones and sets the overflow flag. Counting up from all ones goes to the hold value and sets the overflow flag.
- R8: In clock-generation mode (control bits [2:1] = 10), the count goes up and reloads from hold after all ones. clk_out toggles on each reload, and the overflow flag is not set.
- R9: irq is high whenever either flag is set. The flags are cleared only by writing 1 to their bit at address 3; writing 0 leaves them unchanged.
- R10: With run clear, the count holds. A write to address 1 loads the count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 16 | Read data, combinational on rd_addr |
| trig_in | input | 1 | External trigger / direction pin, idle high |
| clk_out | output | 1 | Square-wave output of clock-generation mode |
| irq | output | 1 | Interrupt request: OR of the two flags |

## Verification
A wrong count or a bad wrap decision shows up on the count read within a single tick. The flags show it in the cycle after the wrap, and irq follows the flags with no delay.

An edge detector stuck in the wrong state would either miss a capture or produce a second one. This is visible through the hold register and the event flag three clocks after the pin moves.

A wrong direction or reload choice in up/down mode changes the count sequence at the first boundary crossing. A misplaced toggle in clock-generation mode puts clk_out out of phase after the first reload.

// File: rtl/uct_pkg.sv
package uct_pkg;

    typedef enum logic [1:0] {
        MODE_CAPT   = 2'b00,
        MODE_RELOAD = 2'b01,
        MODE_CLKGEN = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_COUNT = 2'd1,
        ADDR_HOLD  = 2'd2,
        ADDR_FLAGS = 2'd3
    } addr_e;

    // bit 4 dir_en, bit 3 ext_en, bits 2:1 mode, bit 0 run
    typedef struct packed {
        logic  dir_en;
        logic  ext_en;
        mode_e mode;
        logic  run;
    } ctrl_t;

    localparam int CTRL_W = 5;

    typedef enum logic {
        TRG_HIGH = 1'b0,
        TRG_LOW  = 1'b1
    } trg_state_e;

endpackage

// File: rtl/uct_trig_detect.sv
module uct_trig_detect
    import uct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    trg_state_e             state_q;
    trg_state_e             state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRG_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRG_HIGH: if (!level) state_d = TRG_LOW;
            TRG_LOW:  if (level)  state_d = TRG_HIGH;
        endcase
    end

    always_comb begin
        fall = (state_q == TRG_HIGH) && !level;
    end

endmodule

// File: rtl/uct_count_core.sv
module uct_count_core
    import uct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  mode_e            mode,
    input  logic             dir_en,
    input  logic             ext_en,
    input  logic             dir_up,
    input  logic             fall,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf_set,
    output logic             ext_hit,
    output logic             cap_en,
    output logic             clk_out
);

    localparam logic [CNT_W-1:0] CNT_TOP    = '1;
    localparam logic [CNT_W-1:0] CNT_BOTTOM = '0;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic             updown;
    logic             count_up;
    logic             reload_kind;
    logic             at_edge;
    logic             wrap;
    logic             ext_reload;
    logic             toggle;
    logic             clk_q;

    always_comb begin
        updown      = (mode == MODE_RELOAD) && dir_en;
        count_up    = !updown || dir_up;
        reload_kind = (mode == MODE_RELOAD) || (mode == MODE_CLKGEN);
        at_edge     = count_up ? (count_q == CNT_TOP) : (count_q == reload_val);
        wrap        = run && at_edge;
        ext_reload  = fall && ext_en && (mode == MODE_RELOAD) && !dir_en;
        cap_en      = fall && ext_en && ((mode == MODE_CAPT) || (mode == MODE_RSVD));
        ext_hit     = fall && ext_en && !updown;
        ovf_set     = wrap && (mode != MODE_CLKGEN);
        toggle      = wrap && (mode == MODE_CLKGEN);
    end

    always_comb begin
        count_d = count_q;
        if (run) begin
            if (count_up) begin
                if (at_edge) count_d = reload_kind ? reload_val : CNT_BOTTOM;
                else         count_d = count_q + 1'b1;
            end else begin
                if (at_edge) count_d = CNT_TOP;
                else         count_d = count_q - 1'b1;
            end
        end
        if (ext_reload) count_d = reload_val;
        if (load_en)    count_d = load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= CNT_BOTTOM;
            clk_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            if (toggle) clk_q <= !clk_q;
        end
    end

    assign count   = count_q;
    assign clk_out = clk_q;

endmodule

// File: rtl/updown_capture_timer.sv
module updown_capture_timer
    import uct_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             trig_in,
    output logic             clk_out,
    output logic             irq
);

    localparam int PAD_CTRL  = CNT_W - CTRL_W;
    localparam int PAD_FLAGS = CNT_W - 2;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] hold_q;
    logic             ovf_q;
    logic             ext_q;
    logic [CNT_W-1:0] count_w;
    logic             trig_level;
    logic             trig_fall;
    logic             ovf_set_w;
    logic             ext_hit_w;
    logic             cap_en_w;
    logic             wr_ctrl;
    logic             wr_count;
    logic             wr_hold;
    logic             wr_flags;

    always_comb begin
        wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
        wr_count = wr_en && (wr_addr == ADDR_COUNT);
        wr_hold  = wr_en && (wr_addr == ADDR_HOLD);
        wr_flags = wr_en && (wr_addr == ADDR_FLAGS);
    end

    uct_trig_detect #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_trig (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (trig_in),
        .level(trig_level),
        .fall (trig_fall)
    );

    uct_count_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_q.run),
        .mode      (ctrl_q.mode),
        .dir_en    (ctrl_q.dir_en),
        .ext_en    (ctrl_q.ext_en),
        .dir_up    (trig_level),
        .fall      (trig_fall),
        .reload_val(hold_q),
        .load_en   (wr_count),
        .load_val  (wr_data),
        .count     (count_w),
        .ovf_set   (ovf_set_w),
        .ext_hit   (ext_hit_w),
        .cap_en    (cap_en_w),
        .clk_out   (clk_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            hold_q <= '0;
            ovf_q  <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (cap_en_w)     hold_q <= count_w;
            else if (wr_hold) hold_q <= wr_data;
            if (ovf_set_w)                 ovf_q <= 1'b1;
            else if (wr_flags && wr_data[0]) ovf_q <= 1'b0;
            if (ext_hit_w)                 ext_q <= 1'b1;
            else if (wr_flags && wr_data[1]) ext_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL:  rd_data = {{PAD_CTRL{1'b0}}, ctrl_q};
            ADDR_COUNT: rd_data = count_w;
            ADDR_HOLD:  rd_data = hold_q;
            ADDR_FLAGS: rd_data = {{PAD_FLAGS{1'b0}}, ext_q, ovf_q};
        endcase
    end

    assign irq = ovf_q || ext_q;

endmodule

// File: rtl/uct_checker.sv
module uct_checker
    import uct_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             irq,
    input logic             clk_out,
    input logic             run,
    input mode_e            mode,
    input logic             dir_en,
    input logic             ext_en,
    input logic             dir_up,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] hold,
    input logic             load_en,
    input logic             cap_en,
    input logic             ovf_flag
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    AST_CAPTURE_PREWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (hold == $past(count))); // R3

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_CAPT && count == ALL_ONES && !load_en)
        |=> (count == '0 && ovf_flag)); // R1

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode == MODE_RELOAD && dir_en && !dir_up && count == hold && !load_en)
        |=> (count == ALL_ONES && ovf_flag)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && wr_addr == 2'd3)) |=> irq); // R9

    AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_out) |-> $past(run && mode == MODE_CLKGEN)); // R8

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_en && !ext_en) |=> $stable(count)); // R10

endmodule

bind updown_capture_timer uct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .irq     (irq),
    .clk_out (clk_out),
    .run     (ctrl_q.run),
    .mode    (ctrl_q.mode),
    .dir_en  (ctrl_q.dir_en),
    .ext_en  (ctrl_q.ext_en),
    .dir_up  (trig_level),
    .count   (count_w),
    .hold    (hold_q),
    .load_en (wr_count),
    .cap_en  (cap_en_w),
    .ovf_flag(ovf_q)
);

// File: tb/updown_capture_timer_tb.sv
`timescale 1ns/1ps
module updown_capture_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_addr = 2'd0;
    logic        trig_in = 1'b1;
    wire  [15:0] rd_data;
    wire         clk_out;
    wire         irq;

    localparam int SRC_IRQ = 4;
    localparam int SRC_CLK = 5;

    typedef struct {
        int          src;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    event  sample_ev;
    int    n_checks = 0;
    int    n_errs   = 0;
    bit    done     = 1'b0;

    always #2.5 clk = ~clk;

    updown_capture_timer u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .trig_in(trig_in),
        .clk_out(clk_out),
        .irq    (irq)
    );

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                item_t       it;
                logic [15:0] act;
                it = exp_q.pop_front();
                if (it.src == SRC_IRQ)      act = {15'b0, irq};
                else if (it.src == SRC_CLK) act = {15'b0, clk_out};
                else                        act = rd_data;
                n_checks++;
                if (act !== it.exp) begin
                    n_errs++;
                    $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input int src, input logic [15:0] v, input string tag);
        @(negedge clk);
        if (src < 4) rd_addr = src[1:0];
        #1;
        exp_q.push_back('{src, v, tag});
        ->sample_ev;
        #0.5;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // exactly k ticks (k >= 2) with the given control value plus run
    task automatic run_for(input int k, input logic [15:0] ctl);
        wr(2'd0, ctl | 16'h0001);
        repeat (k - 2) @(negedge clk);
        wr(2'd0, ctl);
    endtask

    task automatic pulse();
        @(negedge clk) trig_in = 1'b0;
        repeat (4) @(negedge clk);
        trig_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        expect_val(0, 16'h0000, "R2 ctrl reset");
        expect_val(1, 16'h0000, "R2 count reset");
        expect_val(2, 16'h0000, "R2 hold reset");
        expect_val(3, 16'h0000, "R2 flags reset");
        expect_val(SRC_IRQ, 16'h0, "R2 irq reset");
        expect_val(SRC_CLK, 16'h0, "R2 clk_out reset");
        wr(2'd0, 16'h001A);
        expect_val(0, 16'h001A, "R2 ctrl readback");
        wr(2'd0, 16'h0000);

        // R10 load, run, hold
        wr(2'd1, 16'h0010);
        run_for(5, 16'h0000);
        expect_val(1, 16'h0015, "R10 count after 5 ticks");
        repeat (3) @(negedge clk);
        expect_val(1, 16'h0015, "R10 count held while stopped");

        // R1 wrap in capture mode, R9 flag clearing
        wr(2'd1, 16'hFFFE);
        run_for(2, 16'h0000);
        expect_val(1, 16'h0000, "R1 wrap to zero");
        expect_val(3, 16'h0001, "R1 overflow flag");
        expect_val(SRC_IRQ, 16'h1, "R9 irq on overflow");
        wr(2'd3, 16'h0000);
        expect_val(3, 16'h0001, "R9 zero write keeps flag");
        wr(2'd3, 16'h0002);
        expect_val(3, 16'h0001, "R9 other-bit clear keeps flag");
        wr(2'd3, 16'h0001);
        expect_val(3, 16'h0000, "R9 flag cleared");
        expect_val(SRC_IRQ, 16'h0, "R9 irq low after clear");

        // R3 capture on falling edge
        wr(2'd0, 16'h0008);
        wr(2'd1, 16'h4321);
        pulse();
        expect_val(2, 16'h4321, "R3 captured count");
        expect_val(3, 16'h0002, "R3 event flag");
        wr(2'd3, 16'h0003);
        wr(2'd1, 16'h1111);
        @(negedge clk) trig_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h2222;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        trig_in = 1'b1;
        repeat (4) @(negedge clk);
        expect_val(2, 16'h1111, "R3 capture sees pre-write count");
        expect_val(1, 16'h2222, "R3 write lands");
        wr(2'd3, 16'h0003);

        // R4 external enable clear: no effect
        wr(2'd0, 16'h0000);
        pulse();
        expect_val(2, 16'h1111, "R4 hold untouched");
        expect_val(1, 16'h2222, "R4 count untouched");
        expect_val(3, 16'h0000, "R4 no flag");

        // R5 reload mode up count
        wr(2'd2, 16'h1234);
        wr(2'd1, 16'hFFFE);
        run_for(3, 16'h0002);
        expect_val(1, 16'h1235, "R5 reload then count");
        expect_val(3, 16'h0001, "R5 overflow flag");
        wr(2'd3, 16'h0003);

        // R6 external reload
        wr(2'd0, 16'h000A);
        wr(2'd1, 16'h0500);
        pulse();
        expect_val(1, 16'h1234, "R6 count reloaded");
        expect_val(3, 16'h0002, "R6 event flag");
        expect_val(SRC_IRQ, 16'h1, "R9 irq on event flag");
        wr(2'd3, 16'h0003);

        // R7 up/down
        wr(2'd2, 16'h0100);
        wr(2'd1, 16'h0102);
        wr(2'd0, 16'h0012);
        @(negedge clk) trig_in = 1'b0;
        repeat (4) @(negedge clk);
        run_for(3, 16'h0012);
        expect_val(1, 16'hFFFF, "R7 down wrap to all ones");
        expect_val(3, 16'h0001, "R7 down overflow flag");
        wr(2'd3, 16'h0001);
        @(negedge clk) trig_in = 1'b1;
        repeat (4) @(negedge clk);
        wr(2'd1, 16'hFFFE);
        run_for(2, 16'h0012);
        expect_val(1, 16'h0100, "R7 up wrap to hold");
        expect_val(3, 16'h0001, "R7 up overflow flag");
        wr(2'd3, 16'h0003);

        // R8 clock generation
        wr(2'd0, 16'h0004);
        wr(2'd2, 16'hFFFE);
        wr(2'd1, 16'hFFFE);
        run_for(2, 16'h0004);
        expect_val(SRC_CLK, 16'h1, "R8 first toggle");
        expect_val(1, 16'hFFFE, "R8 reloaded count");
        expect_val(3, 16'h0000, "R8 no overflow flag");
        run_for(2, 16'h0004);
        expect_val(SRC_CLK, 16'h0, "R8 second toggle");

        @(negedge clk);
        done = 1'b1;
        report();
        $finish;
    end

endmodule